// File: doc/BRIEF.md
# Line Test Pattern Generator

This block sits in the transmit path of a T1/E1 framer. It takes the outgoing line bit stream one bit per clock and, when a test pattern is selected, puts that pattern on the line in place of the system data. Two patterns are unframed and own every bit position: continuous ones (alarm indication signal) and an alternating one/zero stream. The other two are framed: a 20-stage quasi-random signal with zero-run suppression, and a 2^15-1 pseudorandom sequence. In the framed modes only payload bits carry the pattern. Framing, data-link and CRC bits come from the surrounding framer and pass through unchanged.

The framer marks each bit with three qualifiers: a frame-start strobe, a payload flag and an overhead flag. The pattern select is read only at a frame start, so a pattern never begins or ends in the middle of a frame. The output is registered, so there is one clock of latency in every mode.

Top module: `line_test_pattern_gen`

## Requirements
- R1: While `rstN` is low, `lineOut` is 0, no pattern is active, and both generators are loaded with all ones.
- R2: With no pattern active, `lineOut` equals the `sysData` bit from one clock earlier.
- R3: `patSel` bit 0 selects continuous ones: `lineOut` is 1 for every bit, overhead bits included.
- R4: `patSel` bit 1 selects the alternating pattern on every bit. The first bit after the pattern becomes active is 1, and each following bit is the inverse of the one before it.
- R5: `patSel` bit 3 selects the quasi-random signal. The register has stages 1..20 and shifts toward stage 20. Stage 1 loads stage 17 XOR stage 20. The output bit is stage 20, forced to 1 whenever stages 6 through 19 are all 0. The register steps once per payload bit, after that bit's output is formed. The period is 1,048,575 bits.
- R6: `patSel` bit 2 selects the 2^15-1 sequence with polynomial x^15+x^14+1. Stage 1 loads stage 14 XOR stage 15, and the output is stage 15. The register steps once per payload bit, so the sequence of payload bits repeats every 32,767 payload bits.
- R7: In the quasi-random and pseudorandom modes, a bit is a payload bit only when `payloadBit` is 1 and `overheadBit` is 0. Every other bit passes `sysData` through with one clock of latency, and the generator does not step on it.
- R8: When more than one `patSel` bit is set, the priority from highest to lowest is bit 0, bit 1, bit 3, bit 2.
- R9: `patSel` is sampled only on a bit with `frameStart` high, and the new pattern already applies to that bit. A change in `patSel` at any other time has no effect until the next frame start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one line bit per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| patSel | input | 4 | Pattern select: bit 0 ones, bit 1 alternating, bit 2 2^15-1, bit 3 quasi-random |
| frameStart | input | 1 | High on the first bit of each frame |
| payloadBit | input | 1 | High on payload bit positions |
| overheadBit | input | 1 | High on framing, data-link and CRC positions |
| sysData | input | 1 | Serial data from the system side |
| lineOut | output | 1 | Registered serial line data |

## Verification
Each stimulus uses DS1-sized frames of 193 bits with random system data. Random data in pass-through separates a transparent path from a stuck or inverted one. Random data under the ones and alternating patterns shows that framing bits are overwritten as well. Payload bits that also carry the overhead flag show that overhead wins, and that a generator does not step on those bits. Combined select values tell the priority order apart from a plain OR of the patterns. A select change in mid-frame tells frame-aligned switching apart from immediate switching. A pseudorandom run longer than one period, compared against its own start, tells the right length and polynomial apart from a wrong one. A long quasi-random run is checked bit by bit against an arithmetic model that includes the zero-run override.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  localparam int SEL_W    = 4;
  localparam int SEL_AIS  = 0;
  localparam int SEL_ALT  = 1;
  localparam int SEL_PRBS = 2;
  localparam int SEL_QRSS = 3;

  typedef enum logic [2:0] {
    MODE_NONE,
    MODE_AIS,
    MODE_ALT,
    MODE_QRSS,
    MODE_PRBS
  } mode_t;

  typedef struct packed {
    logic useAis;
    logic useAlt;
    logic useQrss;
    logic usePrbs;
    logic payloadHit;
    logic advQrss;
    logic advPrbs;
  } strobe_t;
endpackage

// File: rtl/tpg_lfsr.sv
module tpg_lfsr #(
  parameter int LEN = 15,
  parameter int TAP = 14
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           advance,
  output logic [LEN-1:0] state
);
  localparam logic [LEN-1:0] SEED = '1;

  logic [LEN-1:0] shifted;
  logic [LEN-1:0] nextState;

  always_comb begin
    shifted = {state[LEN-2:0], state[TAP-1] ^ state[LEN-1]};
    nextState = (shifted == '0) ? SEED : shifted;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= SEED;
    else if (advance) state <= nextState;
  end

  // R5 and R6: a step always moves the register to a new state
  assert_step_moves_R6: assert property (@(posedge clk) disable iff (!rstN)
    advance |=> state != $past(state));
endmodule

// File: rtl/tpg_ctrl.sv
module tpg_ctrl
  import tpg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] selBits,
  input  logic             frameStart,
  input  logic             payloadBit,
  input  logic             overheadBit,
  output strobe_t          strb
);
  mode_t activeMode;
  mode_t effMode;

  function automatic mode_t decodeSel(input logic [SEL_W-1:0] s);
    if (s[SEL_AIS])       return MODE_AIS;
    else if (s[SEL_ALT])  return MODE_ALT;
    else if (s[SEL_QRSS]) return MODE_QRSS;
    else if (s[SEL_PRBS]) return MODE_PRBS;
    else                  return MODE_NONE;
  endfunction

  always_comb effMode = frameStart ? decodeSel(selBits) : activeMode;

  always_ff @(posedge clk) begin
    if (!rstN) activeMode <= MODE_NONE;
    else if (frameStart) activeMode <= effMode;
  end

  always_comb begin
    strb.useAis     = (effMode == MODE_AIS);
    strb.useAlt     = (effMode == MODE_ALT);
    strb.useQrss    = (effMode == MODE_QRSS);
    strb.usePrbs    = (effMode == MODE_PRBS);
    strb.payloadHit = payloadBit & ~overheadBit;
    strb.advQrss    = strb.useQrss & strb.payloadHit;
    strb.advPrbs    = strb.usePrbs & strb.payloadHit;
  end
endmodule

// File: rtl/tpg_datapath.sv
module tpg_datapath
  import tpg_pkg::*;
#(
  parameter int QLEN = 20,
  parameter int QTAP = 17,
  parameter int QZHI = 19,
  parameter int QZLO = 6,
  parameter int PLEN = 15,
  parameter int PTAP = 14
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strb,
  input  logic    dataIn,
  output logic    dataOut
);
  logic [QLEN-1:0] qState;
  logic [PLEN-1:0] pState;
  logic            altPhase;
  logic            qrssBit;
  logic            prbsBit;
  logic            nextOut;

  tpg_lfsr #(.LEN(QLEN), .TAP(QTAP)) uQrss (
    .clk(clk), .rstN(rstN), .advance(strb.advQrss), .state(qState)
  );

  tpg_lfsr #(.LEN(PLEN), .TAP(PTAP)) uPrbs (
    .clk(clk), .rstN(rstN), .advance(strb.advPrbs), .state(pState)
  );

  always_comb begin
    qrssBit = qState[QLEN-1] | ~(|qState[QZHI-1:QZLO-1]);
    prbsBit = pState[PLEN-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) altPhase <= 1'b1;
    else altPhase <= strb.useAlt ? ~altPhase : 1'b1;
  end

  always_comb begin
    if (strb.useAis)                        nextOut = 1'b1;
    else if (strb.useAlt)                   nextOut = altPhase;
    else if (strb.useQrss && strb.payloadHit) nextOut = qrssBit;
    else if (strb.usePrbs && strb.payloadHit) nextOut = prbsBit;
    else                                    nextOut = dataIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) dataOut <= 1'b0;
    else dataOut <= nextOut;
  end

  assert_ais_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.useAis |=> dataOut);

  assert_idle_pass_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.useAis | strb.useAlt | strb.useQrss | strb.usePrbs) |=> dataOut == $past(dataIn));

  assert_overhead_pass_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.useQrss | strb.usePrbs) && !strb.payloadHit |=> dataOut == $past(dataIn));

  assert_alt_flips_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.useAlt && $past(strb.useAlt) |=> dataOut != $past(dataOut));
endmodule

// File: rtl/line_test_pattern_gen.sv
module line_test_pattern_gen
  import tpg_pkg::*;
#(
  parameter int QRSS_LEN = 20,
  parameter int QRSS_TAP = 17,
  parameter int QRSS_ZHI = 19,
  parameter int QRSS_ZLO = 6,
  parameter int PRBS_LEN = 15,
  parameter int PRBS_TAP = 14
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] patSel,
  input  logic       frameStart,
  input  logic       payloadBit,
  input  logic       overheadBit,
  input  logic       sysData,
  output logic       lineOut
);
  strobe_t strb;

  tpg_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .selBits(patSel), .frameStart(frameStart),
    .payloadBit(payloadBit), .overheadBit(overheadBit), .strb(strb)
  );

  tpg_datapath #(
    .QLEN(QRSS_LEN), .QTAP(QRSS_TAP), .QZHI(QRSS_ZHI), .QZLO(QRSS_ZLO),
    .PLEN(PRBS_LEN), .PTAP(PRBS_TAP)
  ) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .dataIn(sysData), .dataOut(lineOut)
  );
endmodule

// File: tb/tb_line_test_pattern_gen.sv
module tb_line_test_pattern_gen;
  localparam int FRAME_BITS = 193;
  localparam int PERIOD15   = 32767;
  localparam int WIN        = 64;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] patSel = 4'd0;
  logic frameStart = 1'b0, payloadBit = 1'b0, overheadBit = 1'b0, sysData = 1'b0;
  logic lineOut;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  // bench model: 0 none, 1 ones, 2 alternating, 3 quasi-random, 4 pseudorandom
  int mMode = 0;
  logic mAlt = 1'b1;
  logic [19:0] mq = '1;
  logic [14:0] mp = '1;
  int suppressed = 0;
  int prbsIdx = 0;
  bit capPrbs = 0;
  logic [WIN-1:0] firstWin;

  line_test_pattern_gen dut (
    .clk(clk), .rstN(rstN), .patSel(patSel), .frameStart(frameStart),
    .payloadBit(payloadBit), .overheadBit(overheadBit), .sysData(sysData),
    .lineOut(lineOut)
  );

  always #2.5 clk = ~clk;

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WATCHDOG) begin
      total++; bad++;
      $display("FAIL watchdog: actual cycles=%0d expected below %0d", cycles, WATCHDOG);
      summary();
    end
  end

  function automatic int decode(input logic [3:0] s);
    if (s[0]) return 1;
    if (s[1]) return 2;
    if (s[3]) return 3;
    if (s[2]) return 4;
    return 0;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // one line bit: drive at negedge, compare after the register edge
  task automatic oneBit(input string tag, input logic [3:0] s, input logic fs,
                        input logic pay, input logic ovh, input logic din);
    int eff;
    logic hit, exp, qout;
    patSel = s; frameStart = fs; payloadBit = pay; overheadBit = ovh; sysData = din;
    eff = fs ? decode(s) : mMode;
    if (fs) mMode = eff;
    hit = pay & ~ovh;
    qout = mq[19] | (mq[18:5] == 14'd0);
    case (eff)
      1: exp = 1'b1;
      2: exp = mAlt;
      3: exp = hit ? qout : din;
      4: exp = hit ? mp[14] : din;
      default: exp = din;
    endcase
    mAlt = (eff == 2) ? ~mAlt : 1'b1;
    if (eff == 3 && hit) begin
      if (!mq[19] && mq[18:5] == 14'd0) suppressed++;
      mq = {mq[18:0], mq[16] ^ mq[19]};
    end
    if (eff == 4 && hit) mp = {mp[13:0], mp[13] ^ mp[14]};
    @(posedge clk);
    @(negedge clk);
    check(tag, lineOut, exp);
    if (capPrbs && eff == 4 && hit) begin
      if (prbsIdx < WIN) firstWin[prbsIdx] = lineOut;
      else if (prbsIdx >= PERIOD15 && prbsIdx < PERIOD15 + WIN)
        check("R6 period", lineOut, firstWin[prbsIdx - PERIOD15]);
      prbsIdx++;
    end
  endtask

  // DS1-like frame: bit 0 framing, bits 1..192 payload; dl marks some payload as overhead
  task automatic frame(input string tag, input logic [3:0] s, input bit dl,
                       input int changeAt, input logic [3:0] s2);
    for (int b = 0; b < FRAME_BITS; b++) begin
      logic [3:0] cur;
      logic ovh;
      cur = (changeAt >= 0 && b >= changeAt) ? s2 : s;
      ovh = (b == 0) || (dl && (b % 48 == 5));
      oneBit(tag, cur, b == 0, b != 0, ovh, 1'($urandom & 1));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset output", lineOut, 1'b0);
    rstN = 1'b1;

    frame("R2 pass-through", 4'b0000, 0, -1, 4'b0000);
    frame("R2 pass-through", 4'b0000, 1, -1, 4'b0000);
    frame("R3 all ones", 4'b0001, 0, -1, 4'b0000);
    frame("R3 all ones", 4'b0001, 1, -1, 4'b0000);
    frame("R4 alternating", 4'b0010, 0, -1, 4'b0000);
    frame("R4 alternating", 4'b0010, 1, -1, 4'b0000);
    frame("R8 priority ones", 4'b1111, 0, -1, 4'b0000);
    frame("R8 priority alternating", 4'b1110, 0, -1, 4'b0000);
    frame("R8 priority quasi-random", 4'b1100, 1, -1, 4'b0000);
    frame("R9 mid-frame change ignored", 4'b0000, 0, 50, 4'b0001);
    frame("R9 change at frame start", 4'b0000, 0, -1, 4'b0000);
    frame("R9 mid-frame change ignored", 4'b0010, 0, 77, 4'b0000);
    frame("R9 change at frame start", 4'b0000, 0, -1, 4'b0000);

    // pseudorandom from seed, with overhead-flagged payload bits (R7)
    capPrbs = 1;
    for (int f = 0; f < 180; f++) frame("R6 R7 pseudorandom", 4'b0100, 1, -1, 4'b0000);
    capPrbs = 0;
    check("R6 period window reached", 1'(prbsIdx >= PERIOD15 + WIN), 1'b1);

    // quasi-random, including zero-run override (R5)
    for (int f = 0; f < 450; f++) frame("R5 R7 quasi-random", 4'b1000, f[0], -1, 4'b0000);
    $display("quasi-random bits forced by zero-run rule: %0d", suppressed);

    frame("R2 pass-through after patterns", 4'b0000, 0, -1, 4'b0000);
    summary();
  end
endmodule